// File: doc/BRIEF.md
# Host Register File and Command Decoder

This block is the byte-wide register window that a host processor uses to drive a bus-controller chip. The host presents an address, which is shifted right by a run-time shift amount and reduced to one of sixteen register slots. Four of those slots have one meaning for reads and another for writes. Reads return live status, interrupt cause, sequence step and FIFO flags. Writes at the same slots land in target-side settings that the read side never shows.

A write to the command slot is decoded into a DMA flag (bit 7) and a 7-bit opcode (bits 6:0). A few opcodes act on this block's own state: flush, chip reset, bus reset and enable selection. A fixed set of transfer and selection opcodes is passed to the neighbouring engines as a one-cycle start pulse. Any other opcode is dropped without effect. When a recognised command carries the DMA flag, the live transfer count is reloaded from the count bytes last written by the host. A done strobe and two error strobes from the transfer logic feed the status and interrupt registers. Reading the interrupt-cause register acknowledges the interrupt.

Reads are combinational: `rdata` is valid in the same cycle as `rd_en`. Every side effect of a read or write takes hold at the next rising clock edge.

Top module: `host_regfile_ctl`

## Requirements
- R1: After reset, status, interrupt cause, sequence step, flags, command and live count-low/count-mid all read 0x00. Config-1 (slot 8) reads 0x07. Slot 14 reads the chip code 0x04. `irq` is low.
- R2: The register slot is the low 4 bits of `addr >> addr_shift`. Address bits below the shift are ignored.
- R3: Slots 4, 5, 6 and 7 read status, interrupt cause, sequence step and flags. Host writes to slots 4 to 7, and to slots 2, 9, 10, 13, 14 and 15, leave every read value unchanged.
- R4: Writing slot 0 or 1 stores a pending count byte without changing the live count read back there, and clears status bit 4 (terminal count). A recognised command with bit 7 set copies the pending bytes into the live count. A command with bit 7 clear does not.
- R5: A read of slot 5 returns the cause value held before the read. At the following edge it clears status bits 6, 5 and 7 and drops `irq`.
- R6: Opcode 0x01 (flush) sets the interrupt cause to 0x08 and clears sequence step and flags. It leaves `irq` as it was.
- R7: Opcode 0x03 (bus reset) sets the interrupt cause to 0x80. It also sets status bit 7 and raises `irq`, unless bit 6 of the last value written to config-1 is set.
- R8: Opcode 0x44 (enable selection) clears the interrupt cause to 0x00.
- R9: Opcode 0x02 returns every register to its R1 value and drops `irq`. This includes config-2/config-3 (slots 11 and 12), which otherwise read back what was written.
- R10: A command whose opcode is not among 0x00, 0x01, 0x02, 0x03, 0x10, 0x11, 0x12, 0x1A, 0x42, 0x43 and 0x44 changes nothing. The command slot keeps its old value, the live count is not reloaded, and no start pulse is issued.
- R11: A `xfer_done` pulse sets status bit 4, sets the interrupt cause to 0x10, clears sequence step, flags and the live count, and raises `irq`. When it coincides with a host access, its effects are applied after those of the access.
- R12: Opcodes 0x10, 0x11, 0x12, 0x1A, 0x42 and 0x43 produce a one-cycle `cmd_start` pulse in the cycle after the write. `cmd_op` carries the opcode and `cmd_dma` carries bit 7. Every recognised command byte is readable at slot 3.
- R13: `err_gross` sets status bit 6 and `err_parity` sets status bit 5. Neither changes `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr_shift | input | SHIFT_W | Right shift applied to the address before decoding |
| addr | input | ADDR_W | Host byte address |
| rd_en | input | 1 | Host read strobe; side effects at the next edge |
| wr_en | input | 1 | Host write strobe |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Read data for the addressed slot, combinational |
| err_gross | input | 1 | Gross-error report from transfer logic |
| err_parity | input | 1 | Parity-error report from transfer logic |
| xfer_done | input | 1 | Transfer-complete strobe from the DMA engine |
| irq | output | 1 | Interrupt line to the host |
| cmd_start | output | 1 | One-cycle pulse handing a command to the engines |
| cmd_op | output | 7 | Opcode of the last handed-off command |
| cmd_dma | output | 1 | DMA flag of the last handed-off command |

## Verification
The edge case with the most risk is an interrupt acknowledge, a read of slot 5, arriving in the same cycle that the transfer engine reports completion. The bench drives `rd_en` on slot 5 and `xfer_done` together in one cycle. It checks that the returned byte is the old cause, and that afterwards `irq` is high, status bit 4 is set and the cause reads 0x10. That shows the completion was not swallowed by the acknowledge. A second collision pairs a count-byte write, which clears terminal count, with `xfer_done`, which sets it. Status must then show terminal count set.

// File: rtl/host_regs_pkg.sv
package host_regs_pkg;

    localparam int IDX_W = 4;

    // Register slots (read meaning; write meaning noted where different)
    localparam logic [IDX_W-1:0] IX_CNT_LO  = 4'h0;
    localparam logic [IDX_W-1:0] IX_CNT_MID = 4'h1;
    localparam logic [IDX_W-1:0] IX_CMD     = 4'h3;
    localparam logic [IDX_W-1:0] IX_STAT    = 4'h4;  // write: target id
    localparam logic [IDX_W-1:0] IX_CAUSE   = 4'h5;  // write: select timeout
    localparam logic [IDX_W-1:0] IX_STEP    = 4'h6;  // write: sync period
    localparam logic [IDX_W-1:0] IX_FLAGS   = 4'h7;  // write: sync offset
    localparam logic [IDX_W-1:0] IX_CFG1    = 4'h8;
    localparam logic [IDX_W-1:0] IX_CFG2    = 4'hB;
    localparam logic [IDX_W-1:0] IX_CFG3    = 4'hC;
    localparam logic [IDX_W-1:0] IX_IDCODE  = 4'hE;

    localparam int ST_PEND   = 7;
    localparam int ST_GROSS  = 6;
    localparam int ST_PARITY = 5;
    localparam int ST_TERM   = 4;
    localparam int CFG1_QUIET = 6;

    localparam logic [7:0] CAUSE_FUNC_DONE = 8'h08;
    localparam logic [7:0] CAUSE_BUS_SVC   = 8'h10;
    localparam logic [7:0] CAUSE_BUS_RST   = 8'h80;
    localparam logic [7:0] CFG1_INIT       = 8'h07;
    localparam logic [7:0] CHIP_CODE       = 8'h04;

    typedef enum logic [2:0] {
        CK_NOP, CK_FLUSH, CK_CHIPRST, CK_BUSRST, CK_ENSEL, CK_HANDOFF, CK_UNKNOWN
    } cmd_kind_e;

    typedef struct packed {
        logic       dma;
        logic [6:0] op;
    } cmd_byte_t;

    typedef struct packed {
        logic [7:0] cnt_lo;
        logic [7:0] cnt_mid;
        logic [7:0] cnt_lo_pend;
        logic [7:0] cnt_mid_pend;
        logic [7:0] cmd;
        logic [7:0] status;
        logic [7:0] cause;
        logic [7:0] step;
        logic [7:0] flags;
        logic [7:0] cfg1;
        logic [7:0] cfg1_wr;
        logic [7:0] cfg2;
        logic [7:0] cfg3;
        logic       irq;
    } regs_t;

    function automatic cmd_kind_e classify(input logic [6:0] op);
        case (op)
            7'h00: return CK_NOP;
            7'h01: return CK_FLUSH;
            7'h02: return CK_CHIPRST;
            7'h03: return CK_BUSRST;
            7'h44: return CK_ENSEL;
            7'h10, 7'h11, 7'h12, 7'h1A, 7'h42, 7'h43: return CK_HANDOFF;
            default: return CK_UNKNOWN;
        endcase
    endfunction

    function automatic regs_t reset_regs();
        regs_t v;
        v      = '0;
        v.cfg1 = CFG1_INIT;
        return v;
    endfunction

endpackage

// File: rtl/hrf_addr_decode.sv
module hrf_addr_decode
    import host_regs_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int SHIFT_W = 2
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic [SHIFT_W-1:0] shift,
    output logic [IDX_W-1:0]   idx
);
    logic [ADDR_W-1:0] shifted;

    always_comb begin
        shifted = addr >> shift;
        idx     = shifted[IDX_W-1:0];
    end
endmodule

// File: rtl/hrf_cmd_decode.sv
module hrf_cmd_decode
    import host_regs_pkg::*;
(
    input  logic [7:0] cmd_in,
    output cmd_byte_t  fields,
    output cmd_kind_e  kind
);
    always_comb begin
        fields = cmd_byte_t'(cmd_in);
        kind   = classify(fields.op);
    end
endmodule

// File: rtl/host_regfile_ctl.sv
module host_regfile_ctl
    import host_regs_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int SHIFT_W = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [SHIFT_W-1:0] addr_shift,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               rd_en,
    input  logic               wr_en,
    input  logic [7:0]         wdata,
    output logic [7:0]         rdata,
    input  logic               err_gross,
    input  logic               err_parity,
    input  logic               xfer_done,
    output logic               irq,
    output logic               cmd_start,
    output logic [6:0]         cmd_op,
    output logic               cmd_dma
);
    logic [IDX_W-1:0] idx;
    cmd_byte_t        dec;
    cmd_kind_e        kind;
    regs_t            r, n;
    logic             start_d;

    hrf_addr_decode #(.ADDR_W(ADDR_W), .SHIFT_W(SHIFT_W)) u_adec (
        .addr(addr), .shift(addr_shift), .idx(idx)
    );

    hrf_cmd_decode u_cdec (.cmd_in(wdata), .fields(dec), .kind(kind));

    // Ordering within a cycle: read acknowledge, host write, error strobes, done.
    always_comb begin
        n       = r;
        start_d = 1'b0;
        if (rd_en && idx == IX_CAUSE) begin
            n.status[ST_GROSS]  = 1'b0;
            n.status[ST_PARITY] = 1'b0;
            n.status[ST_PEND]   = 1'b0;
            n.irq               = 1'b0;
        end
        if (wr_en) begin
            case (idx)
                IX_CNT_LO: begin
                    n.cnt_lo_pend      = wdata;
                    n.status[ST_TERM]  = 1'b0;
                end
                IX_CNT_MID: begin
                    n.cnt_mid_pend     = wdata;
                    n.status[ST_TERM]  = 1'b0;
                end
                IX_CMD: begin
                    if (kind != CK_UNKNOWN) begin
                        n.cmd = wdata;
                        if (dec.dma) begin
                            n.cnt_lo  = r.cnt_lo_pend;
                            n.cnt_mid = r.cnt_mid_pend;
                        end
                        case (kind)
                            CK_FLUSH: begin
                                n.cause = CAUSE_FUNC_DONE;
                                n.step  = '0;
                                n.flags = '0;
                            end
                            CK_CHIPRST: n = reset_regs();
                            CK_BUSRST: begin
                                n.cause = CAUSE_BUS_RST;
                                if (!r.cfg1_wr[CFG1_QUIET]) begin
                                    n.status[ST_PEND] = 1'b1;
                                    n.irq             = 1'b1;
                                end
                            end
                            CK_ENSEL:   n.cause = '0;
                            CK_HANDOFF: start_d = 1'b1;
                            default: ;
                        endcase
                    end
                end
                IX_CFG1: begin
                    n.cfg1    = wdata;
                    n.cfg1_wr = wdata;
                end
                IX_CFG2: n.cfg2 = wdata;
                IX_CFG3: n.cfg3 = wdata;
                default: ;
            endcase
        end
        if (err_gross)  n.status[ST_GROSS]  = 1'b1;
        if (err_parity) n.status[ST_PARITY] = 1'b1;
        if (xfer_done) begin
            n.status[ST_TERM] = 1'b1;
            n.cause           = CAUSE_BUS_SVC;
            n.step            = '0;
            n.flags           = '0;
            n.cnt_lo          = '0;
            n.cnt_mid         = '0;
            n.status[ST_PEND] = 1'b1;
            n.irq             = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r         <= reset_regs();
            cmd_start <= 1'b0;
            cmd_op    <= '0;
            cmd_dma   <= 1'b0;
        end else begin
            r         <= n;
            cmd_start <= start_d;
            if (start_d) begin
                cmd_op  <= dec.op;
                cmd_dma <= dec.dma;
            end
        end
    end

    assign irq = r.irq;

    always_comb begin
        case (idx)
            IX_CNT_LO:  rdata = r.cnt_lo;
            IX_CNT_MID: rdata = r.cnt_mid;
            IX_CMD:     rdata = r.cmd;
            IX_STAT:    rdata = r.status;
            IX_CAUSE:   rdata = r.cause;
            IX_STEP:    rdata = r.step;
            IX_FLAGS:   rdata = r.flags;
            IX_CFG1:    rdata = r.cfg1;
            IX_CFG2:    rdata = r.cfg2;
            IX_CFG3:    rdata = r.cfg3;
            IX_IDCODE:  rdata = CHIP_CODE;
            default:    rdata = 8'h00;
        endcase
    end

    // R5
    ack_drops_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && idx == IX_CAUSE && !xfer_done) |=> (!irq && !r.status[ST_PEND]));

    // R11
    done_raises_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_done |=> (irq && r.status[ST_TERM] && r.cause == CAUSE_BUS_SVC));

    // R7
    bus_reset_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && idx == IX_CMD && kind == CK_BUSRST && !r.cfg1_wr[CFG1_QUIET] && !xfer_done)
        |=> (irq && r.cause == CAUSE_BUS_RST));

    // R10
    unknown_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && idx == IX_CMD && kind == CK_UNKNOWN) |=> ($stable(r.cmd) && !cmd_start));

    // R12
    handoff_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && idx == IX_CMD && kind == CK_HANDOFF) |=> (cmd_start && cmd_op == $past(wdata[6:0])));

    // R4
    count_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && idx == IX_CMD && dec.dma && kind != CK_UNKNOWN && kind != CK_CHIPRST && !xfer_done)
        |=> (r.cnt_lo == $past(r.cnt_lo_pend) && r.cnt_mid == $past(r.cnt_mid_pend)));

endmodule

// File: tb/host_regfile_ctl_test.sv
module host_regfile_ctl_test;
    localparam int ADDR_W  = 8;
    localparam int SHIFT_W = 2;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [SHIFT_W-1:0] addr_shift = 2'd2;
    logic [ADDR_W-1:0]  addr = '0;
    logic               rd_en = 1'b0, wr_en = 1'b0;
    logic [7:0]         wdata = '0;
    logic [7:0]         rdata;
    logic               err_gross = 1'b0, err_parity = 1'b0, xfer_done = 1'b0;
    logic               irq, cmd_start, cmd_dma;
    logic [6:0]         cmd_op;

    int  vectors = 0, miscompares = 0;
    bit  finished = 0;
    logic last_start;

    host_regfile_ctl #(.ADDR_W(ADDR_W), .SHIFT_W(SHIFT_W)) uut (
        .clk(clk), .rst(rst), .addr_shift(addr_shift), .addr(addr),
        .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
        .err_gross(err_gross), .err_parity(err_parity), .xfer_done(xfer_done),
        .irq(irq), .cmd_start(cmd_start), .cmd_op(cmd_op), .cmd_dma(cmd_dma)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, got, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] slot_addr(input int slot);
        return ADDR_W'(slot) << addr_shift;
    endfunction

    task automatic host_write(input int slot, input logic [7:0] v, input bit with_done = 0);
        @(negedge clk);
        addr = slot_addr(slot); wdata = v; wr_en = 1'b1; xfer_done = with_done;
        @(posedge clk); #1;
        wr_en = 1'b0; xfer_done = 1'b0;
        last_start = cmd_start;
    endtask

    task automatic host_read(input int slot, output logic [7:0] v, input bit with_done = 0);
        @(negedge clk);
        addr = slot_addr(slot); rd_en = 1'b1; xfer_done = with_done;
        #1 v = rdata;
        @(posedge clk); #1;
        rd_en = 1'b0; xfer_done = 1'b0;
    endtask

    task automatic read_check(input string req, input int slot, input logic [7:0] exp);
        logic [7:0] v;
        host_read(slot, v);
        check(req, v, exp);
    endtask

    task automatic pulse(input bit d, input bit g, input bit p);
        @(negedge clk);
        xfer_done = d; err_gross = g; err_parity = p;
        @(posedge clk); #1;
        xfer_done = 0; err_gross = 0; err_parity = 0;
    endtask

    task automatic t_reset;
        check("R1 irq", {7'b0, irq}, 8'h00);
        read_check("R1 status", 4, 8'h00);
        read_check("R1 cause", 5, 8'h00);
        read_check("R1 cfg1", 8, 8'h07);
        read_check("R1 idcode", 14, 8'h04);
        read_check("R1 count", 0, 8'h00);
        read_check("R1 cmd", 3, 8'h00);
    endtask

    task automatic t_shift;
        logic [7:0] v;
        addr_shift = 2'd0; read_check("R2 shift0", 8, 8'h07);
        addr_shift = 2'd1;
        @(negedge clk); addr = 8'h11; rd_en = 1; #1 v = rdata; @(posedge clk); #1 rd_en = 0;
        check("R2 shift1 low bit ignored", v, 8'h07);
        addr_shift = 2'd3;
        @(negedge clk); addr = 8'h47; rd_en = 1; #1 v = rdata; @(posedge clk); #1 rd_en = 0;
        check("R2 shift3 low bits ignored", v, 8'h07);
        addr_shift = 2'd2;
    endtask

    task automatic t_bus_reset;
        host_write(3, 8'h03);
        check("R7 irq raised", {7'b0, irq}, 8'h01);
        read_check("R3 status pending", 4, 8'h80);
        read_check("R5 cause returned", 5, 8'h80);
        check("R5 irq dropped", {7'b0, irq}, 8'h00);
        read_check("R5 pending cleared", 4, 8'h00);
        host_write(8, 8'h47);
        host_write(3, 8'h03);
        check("R7 quiet bit suppresses irq", {7'b0, irq}, 8'h00);
        read_check("R7 cause", 5, 8'h80);
        read_check("R7 cfg1 readback", 8, 8'h47);
        host_write(8, 8'h07);
    endtask

    task automatic t_split;
        for (int s = 4; s < 8; s++) host_write(s, 8'hFF);
        host_write(14, 8'h99);
        host_write(2, 8'h55);
        read_check("R3 status", 4, 8'h00);
        read_check("R3 cause", 5, 8'h80);
        read_check("R3 step", 6, 8'h00);
        read_check("R3 flags", 7, 8'h00);
        read_check("R3 idcode", 14, 8'h04);
    endtask

    task automatic t_count;
        host_write(0, 8'h34);
        host_write(1, 8'h12);
        read_check("R4 live not yet loaded", 0, 8'h00);
        host_write(3, 8'h80);
        read_check("R4 reload lo", 0, 8'h34);
        read_check("R4 reload mid", 1, 8'h12);
        read_check("R12 cmd readback", 3, 8'h80);
        host_write(0, 8'h55);
        host_write(3, 8'h00);
        read_check("R4 no reload without flag", 0, 8'h34);
    endtask

    task automatic t_done;
        pulse(1, 0, 0);
        check("R11 irq", {7'b0, irq}, 8'h01);
        read_check("R11 status", 4, 8'h90);
        read_check("R11 count zeroed", 0, 8'h00);
        read_check("R11 cause", 5, 8'h10);
        check("R5 irq after ack", {7'b0, irq}, 8'h00);
        host_write(1, 8'hAA);
        read_check("R4 terminal count cleared", 4, 8'h00);
    endtask

    task automatic t_errors;
        pulse(0, 1, 1);
        check("R13 irq unchanged", {7'b0, irq}, 8'h00);
        read_check("R13 error bits", 4, 8'h60);
        read_check("R5 ack", 5, 8'h10);
        read_check("R5 error bits cleared", 4, 8'h00);
    endtask

    task automatic t_flush;
        host_write(3, 8'h03);
        host_write(3, 8'h01);
        check("R6 irq kept", {7'b0, irq}, 8'h01);
        read_check("R6 step", 6, 8'h00);
        read_check("R6 cause", 5, 8'h08);
        host_write(3, 8'h44);
        read_check("R8 cause cleared", 5, 8'h00);
    endtask

    task automatic t_unknown;
        host_write(0, 8'h66);
        host_write(3, 8'hFF);
        check("R10 no start", {7'b0, last_start}, 8'h00);
        read_check("R10 cmd kept", 3, 8'h44);
        read_check("R10 no reload", 0, 8'h00);
        host_write(3, 8'h2B);
        read_check("R10 cause kept", 5, 8'h00);
    endtask

    task automatic t_handoff;
        host_write(3, 8'h90);
        check("R12 start", {7'b0, last_start}, 8'h01);
        check("R12 op", {1'b0, cmd_op}, 8'h10);
        check("R12 dma", {7'b0, cmd_dma}, 8'h01);
        read_check("R12 cmd readback", 3, 8'h90);
        check("R12 pulse one cycle", {7'b0, cmd_start}, 8'h00);
        read_check("R4 reload by handoff", 0, 8'h66);
        host_write(3, 8'h42);
        check("R12 start2", {7'b0, last_start}, 8'h01);
        check("R12 op2", {1'b0, cmd_op}, 8'h42);
        check("R12 dma2", {7'b0, cmd_dma}, 8'h00);
    endtask

    task automatic t_collide;
        logic [7:0] v;
        host_write(3, 8'h03);
        host_read(5, v, 1);
        check("R5 collide returns old cause", v, 8'h80);
        check("R11 done wins over ack", {7'b0, irq}, 8'h01);
        read_check("R11 collide status", 4, 8'h90);
        read_check("R11 collide cause", 5, 8'h10);
        host_write(0, 8'h01, 1);
        read_check("R11 done wins over count write", 4, 8'h90);
    endtask

    task automatic t_chip_reset;
        host_write(11, 8'h5A);
        read_check("R9 cfg2 readback", 11, 8'h5A);
        host_write(3, 8'h02);
        check("R9 irq", {7'b0, irq}, 8'h00);
        read_check("R9 status", 4, 8'h00);
        read_check("R9 cause", 5, 8'h00);
        read_check("R9 cfg1", 8, 8'h07);
        read_check("R9 cfg2", 11, 8'h00);
        read_check("R9 cmd", 3, 8'h00);
        read_check("R9 idcode", 14, 8'h04);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset;
        t_shift;
        t_bus_reset;
        t_split;
        t_count;
        t_done;
        t_errors;
        t_flush;
        t_unknown;
        t_handoff;
        t_collide;
        t_chip_reset;
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule